// File: doc/BRIEF.md
# Programmable Counter Channel

This block is a single down-counting channel of an interval timer. A clock enable marks the timer ticks, and a gate input lets counting proceed. Software-facing logic elsewhere hands the channel a reload value with a load strobe and a mode code with a mode strobe. The channel presents its live count for readback and drives one output level. When the channel is configured as the interrupt source, the level also appears on an interrupt request pin.

Three behaviours are built. The terminal-count mode drops the output on load and raises it for good once the count has run down. The rate mode produces a one-tick low pulse once per period and reloads itself. The square-wave mode splits each period into a longer-or-equal high phase and a low phase. A reload value of zero stands for the full range of the counter. Counting is binary only.

Top module: `pct_channel`

## Requirements
- R1: After reset the mode code is 3 (square wave), the count reads 0 (full range), the output is high and the channel is counting.
- R2: A load strobe stores reload_val and makes count_rd equal it after the next clock edge, restarting the period. A load wins over a mode write, a tick and a gate edge in the same cycle.
- R3: A reload value of 0 counts as 2^CW ticks and reads back as 0. One tick later it reads 2^CW-1.
- R4: The count changes only on clock edges where tick_en and gate_in are both high, apart from a load or a gate restart. With tick_en low, count_rd is stable.
- R5: Mode-code decoding uses only bits [1:0]. Code 0 (and codes 1, 4, 5) select terminal count. In this mode the output is low after a load. It goes high on the tick that takes the count from 1 to 0, which is N ticks for reload N. It then stays high while the count keeps wrapping, until the next load or mode write.
- R6: Bits [1:0] = 2'b10 (codes 2, 6) select rate mode. For reload N (N >= 2), after e ticks into a period the count reads N-e. The output is low only while the count reads 1. The following tick reloads N.
- R7: Bits [1:0] = 2'b11 (codes 3, 7) select square-wave mode. For reload N, at e = (ticks since load) mod N the count reads N-e. The output is high while e < (N+1)>>1 and low otherwise.
- R8: In rate and square-wave modes, a low gate_in forces the output high after the next edge and freezes the count. A rising gate edge reloads the count from the stored reload value and restarts the period at that edge.
- R9: A mode strobe captures mode_val and stops counting until the next load. After it the output is low for terminal-count decoding and high otherwise.
- R10: In terminal-count mode a low gate_in pauses the count and leaves the output unchanged. A rising gate edge does not reload.
- R11: With IRQ_EN = 1, irq_req equals the output level at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick enable, one clock per tick |
| gate_in | input | 1 | Gate, synchronous to clk |
| reload_val | input | CW | Reload value, 0 means 2^CW |
| load_stb | input | 1 | Load strobe for reload_val |
| mode_val | input | MW | Mode code |
| mode_stb | input | 1 | Mode write strobe |
| count_rd | output | CW | Live down-counter value |
| out_lvl | output | 1 | Channel output level |
| irq_req | output | 1 | Interrupt request (output level when IRQ_EN = 1, else 0) |

## Verification
The bench builds the channel with CW = 16, MW = 3, RST_MODE = 3, GATE_RST = 1 and IRQ_EN = 1. These values make the interrupt pin observable and keep the full-range count reachable. From reset, the square-wave output falls after exactly 32768 ticks with the count reading 0x8000. With a 3-bit mode code, the aliased codes 1, 6 and 7 can be tried against their two-bit decoding. Short reload values of 3 to 10 let odd and even square-wave splits, the rate-mode pulse, gate freezes and restarts, and load priority each be reached within a few cycles.

// File: rtl/pct_pkg.sv
package pct_pkg;

  typedef enum logic [1:0] {
    MK_TERM   = 2'd0,
    MK_RATE   = 2'd1,
    MK_SQUARE = 2'd2
  } mode_kind_e;

  // Only the two low code bits select the behaviour.
  function automatic mode_kind_e decode_mode(input logic [1:0] low2);
    case (low2)
      2'b10:   decode_mode = MK_RATE;
      2'b11:   decode_mode = MK_SQUARE;
      default: decode_mode = MK_TERM;
    endcase
  endfunction

endpackage

// File: rtl/pct_mode_reg.sv
module pct_mode_reg
  import pct_pkg::*;
#(
  parameter int MW       = 3,
  parameter int RST_MODE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_stb,
  input  logic [MW-1:0] mode_val,
  output mode_kind_e    kind_q,
  output mode_kind_e    kind_nxt
);

  logic [MW-1:0] mode_q;
  logic [MW-1:0] mode_nxt;

  always_comb begin
    mode_nxt = mode_stb ? mode_val : mode_q;
    kind_nxt = decode_mode(mode_nxt[1:0]);
    kind_q   = decode_mode(mode_q[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MW'(RST_MODE);
    else        mode_q <= mode_nxt;
  end

  // R9
  mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stb |=> (mode_q == $past(mode_val)));

endmodule

// File: rtl/pct_gate_edge.sv
module pct_gate_edge #(
  parameter bit GATE_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic gate_rise
);

  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= GATE_RST;
    else        gate_q <= gate_in;
  end

  assign gate_rise = gate_in & ~gate_q;

  // R8
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |=> !gate_rise);

endmodule

// File: rtl/pct_down_counter.sv
module pct_down_counter
  import pct_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate_in,
  input  logic          gate_rise,
  input  logic          load_stb,
  input  logic [CW-1:0] reload_val,
  input  logic          mode_stb,
  input  mode_kind_e    kind_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic [CW-1:0] reload_q,
  output logic [CW-1:0] reload_nxt,
  output logic          armed_nxt,
  output logic          term_nxt
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic armed_q;
  logic term_q;
  logic auto_rld;
  logic restart;
  logic step;

  // One tick of the down-counter; at 1 the periodic modes reload.
  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cur,
                                               input logic [CW-1:0] rld,
                                               input logic          periodic);
    if (periodic && cur == ONE) next_count = rld;
    else                        next_count = cur - ONE;
  endfunction

  always_comb begin
    restart = armed_q && !load_stb && !mode_stb && (kind_q != MK_TERM) && gate_rise;
    step    = armed_q && !load_stb && !mode_stb && !restart && tick_en && gate_in;
    auto_rld = step && (kind_q != MK_TERM) && (cnt_q == ONE);

    cnt_nxt    = cnt_q;
    reload_nxt = reload_q;
    armed_nxt  = armed_q;
    term_nxt   = term_q;

    if (load_stb) begin
      reload_nxt = reload_val;
      cnt_nxt    = reload_val;
      armed_nxt  = 1'b1;
      term_nxt   = 1'b0;
    end else if (mode_stb) begin
      armed_nxt = 1'b0;
      term_nxt  = 1'b0;
    end else if (restart) begin
      cnt_nxt = reload_q;
    end else if (step) begin
      cnt_nxt = next_count(cnt_q, reload_q, kind_q != MK_TERM);
      if (kind_q == MK_TERM && cnt_q == ONE) term_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      armed_q  <= 1'b1;
      term_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      reload_q <= reload_nxt;
      armed_q  <= armed_nxt;
      term_q   <= term_nxt;
    end
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (cnt_q == $past(reload_val)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_stb && !gate_rise) |=> $stable(cnt_q));

  // R6
  auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rld |=> (cnt_q == reload_q));

  // R9
  disarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stb && !load_stb) |=> $stable(cnt_q));

endmodule

// File: rtl/pct_out_gen.sv
module pct_out_gen
  import pct_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_kind_e    kind_nxt,
  input  logic          gate_in,
  input  logic          armed_nxt,
  input  logic          term_nxt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] reload_nxt,
  output logic          out_q
);

  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

  logic level_nxt;

  // Zero stands for the full range.
  function automatic logic [CW:0] span(input logic [CW-1:0] v);
    span = (v == '0) ? FULL : {1'b0, v};
  endfunction

  // High while fewer than (N+1)>>1 ticks of the period have elapsed.
  function automatic logic square_high(input logic [CW-1:0] rld,
                                       input logic [CW-1:0] cur);
    logic [CW:0] n;
    logic [CW:0] elapsed;
    logic [CW:0] half;
    n       = span(rld);
    elapsed = n - span(cur);
    half    = (n + 1'b1) >> 1;
    square_high = (elapsed < half);
  endfunction

  always_comb begin
    if (kind_nxt == MK_TERM)        level_nxt = term_nxt;
    else if (!gate_in || !armed_nxt) level_nxt = 1'b1;
    else if (kind_nxt == MK_RATE)   level_nxt = (cnt_nxt != CW'(1));
    else                            level_nxt = square_high(reload_nxt, cnt_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b1;
    else        out_q <= level_nxt;
  end

endmodule

// File: rtl/pct_channel.sv
module pct_channel
  import pct_pkg::*;
#(
  parameter int CW       = 16,
  parameter int MW       = 3,
  parameter int RST_MODE = 3,
  parameter bit GATE_RST = 1'b1,
  parameter bit IRQ_EN   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate_in,
  input  logic [CW-1:0] reload_val,
  input  logic          load_stb,
  input  logic [MW-1:0] mode_val,
  input  logic          mode_stb,
  output logic [CW-1:0] count_rd,
  output logic          out_lvl,
  output logic          irq_req
);

  mode_kind_e    kind_q;
  mode_kind_e    kind_nxt;
  logic          gate_rise;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] reload_q;
  logic [CW-1:0] reload_nxt;
  logic          armed_nxt;
  logic          term_nxt;

  pct_mode_reg #(.MW(MW), .RST_MODE(RST_MODE)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_stb (mode_stb),
    .mode_val (mode_val),
    .kind_q   (kind_q),
    .kind_nxt (kind_nxt)
  );

  pct_gate_edge #(.GATE_RST(GATE_RST)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_in   (gate_in),
    .gate_rise (gate_rise)
  );

  pct_down_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .gate_in    (gate_in),
    .gate_rise  (gate_rise),
    .load_stb   (load_stb),
    .reload_val (reload_val),
    .mode_stb   (mode_stb),
    .kind_q     (kind_q),
    .cnt_q      (count_rd),
    .cnt_nxt    (cnt_nxt),
    .reload_q   (reload_q),
    .reload_nxt (reload_nxt),
    .armed_nxt  (armed_nxt),
    .term_nxt   (term_nxt)
  );

  pct_out_gen #(.CW(CW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind_nxt   (kind_nxt),
    .gate_in    (gate_in),
    .armed_nxt  (armed_nxt),
    .term_nxt   (term_nxt),
    .cnt_nxt    (cnt_nxt),
    .reload_nxt (reload_nxt),
    .out_q      (out_lvl)
  );

  generate
    if (IRQ_EN) begin : g_irq
      assign irq_req = out_lvl;
    end else begin : g_no_irq
      assign irq_req = 1'b0;
    end
  endgenerate

  // R5
  term_low_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && kind_nxt == MK_TERM) |=> !out_lvl);

  // R5
  term_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == MK_TERM && out_lvl && !load_stb && !mode_stb) |=> out_lvl);

  // R8
  gate_low_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_in && kind_nxt != MK_TERM) |=> out_lvl);

  // R6
  rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == MK_RATE && !out_lvl && tick_en && gate_in && !load_stb &&
     !mode_stb && reload_q != CW'(1)) |=> out_lvl);

endmodule

// File: tb/pct_channel_tb_top.sv
`timescale 1ns/1ps
module pct_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        gate_in;
  logic [15:0] reload_val;
  logic        load_stb;
  logic [2:0]  mode_val;
  logic        mode_stb;
  logic [15:0] count_rd;
  logic        out_lvl;
  logic        irq_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pct_channel dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .gate_in    (gate_in),
    .reload_val (reload_val),
    .load_stb   (load_stb),
    .mode_val   (mode_val),
    .mode_stb   (mode_stb),
    .count_rd   (count_rd),
    .out_lvl    (out_lvl),
    .irq_req    (irq_req)
  );

  // Vectors: mode code, reload N, ticks since load, expected count, expected level.
  localparam int NV = 19;
  localparam int V_MODE [NV] = '{0, 0, 0, 2, 2, 2, 2, 3, 3, 3, 3, 3, 3, 3, 3, 7, 6, 1, 1};
  localparam int V_N    [NV] = '{5, 5, 5, 4, 4, 4, 4, 5, 5, 5, 5, 5, 4, 4, 4, 6, 3, 3, 3};
  localparam int V_J    [NV] = '{4, 5, 7, 2, 3, 4, 7, 2, 3, 4, 5, 8, 1, 2, 4, 3, 2, 3, 2};
  localparam int V_CNT  [NV] = '{1, 0, 65534, 2, 1, 4, 1, 3, 2, 1, 5, 2, 3, 2, 4, 3, 1, 0, 1};
  localparam int V_OUT  [NV] = '{0, 1, 1, 1, 0, 1, 0, 1, 0, 0, 1, 0, 1, 0, 1, 0, 0, 1, 0};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic do_mode(input int code);
    mode_val = 3'(code);
    mode_stb = 1'b1;
    @(negedge clk);
    mode_stb = 1'b0;
  endtask

  task automatic do_load(input int n);
    reload_val = 16'(n);
    load_stb   = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic run_ticks(input int j);
    tick_en = 1'b1;
    repeat (j) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; gate_in = 1'b1; reload_val = '0;
    load_stb = 1'b0; mode_val = '0; mode_stb = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count after reset", count_rd, 0);
    check("R1 level after reset", out_lvl, 1);
    check("R11 irq after reset", irq_req, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 full-range count from reset, square wave falls at 32768 ticks (R7)
    run_ticks(1);
    check("R3 wrap from zero", count_rd, 65535);
    check("R7 full range early high", out_lvl, 1);
    run_ticks(32767);
    check("R3 full range half count", count_rd, 32768);
    check("R7 full range falls at half", out_lvl, 0);
    check("R11 irq follows level", irq_req, 0);

    // Vector table: R5 terminal count, R6 rate, R7 square wave
    for (int v = 0; v < NV; v++) begin
      string tag;
      do_mode(V_MODE[v]);
      do_load(V_N[v]);
      run_ticks(V_J[v]);
      tag = (V_MODE[v][1:0] == 2'b10) ? "R6" : (V_MODE[v][1:0] == 2'b11) ? "R7" : "R5";
      check($sformatf("%s vec%0d count", tag, v), count_rd, V_CNT[v]);
      check($sformatf("%s vec%0d level", tag, v), out_lvl, V_OUT[v]);
    end

    // R8 gate in square-wave mode
    do_mode(3);
    do_load(6);
    run_ticks(4);
    check("R7 pre-gate level", out_lvl, 0);
    gate_in = 1'b0; tick_en = 1'b1;
    @(negedge clk);
    check("R8 gate low forces high", out_lvl, 1);
    repeat (3) @(negedge clk);
    check("R8 gate low freezes count", count_rd, 2);
    gate_in = 1'b1;
    @(negedge clk);
    check("R8 gate rise reloads", count_rd, 6);
    check("R8 gate rise level", out_lvl, 1);
    run_ticks(3);
    check("R8 restarted period count", count_rd, 3);
    check("R8 restarted period level", out_lvl, 0);

    // R10 gate pause in terminal-count mode
    do_mode(0);
    do_load(5);
    run_ticks(2);
    gate_in = 1'b0; tick_en = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b0;
    check("R10 paused count", count_rd, 3);
    check("R10 paused level", out_lvl, 0);
    gate_in = 1'b1;
    run_ticks(3);
    check("R10 resume without reload", count_rd, 0);
    check("R10 terminal reached", out_lvl, 1);

    // R4 no tick, then sparse ticks
    do_mode(2);
    do_load(9);
    run_ticks(2);
    repeat (5) @(negedge clk);
    check("R4 idle count stable", count_rd, 7);
    for (int k = 0; k < 4; k++) begin
      tick_en = (k % 2 == 0);
      @(negedge clk);
    end
    tick_en = 1'b0;
    check("R4 sparse ticks", count_rd, 5);

    // R9 mode write disarms
    do_mode(3);
    do_load(8);
    run_ticks(2);
    check("R7 before mode write", out_lvl, 1);
    do_mode(0);
    check("R9 terminal decode low", out_lvl, 0);
    run_ticks(3);
    check("R9 count halted", count_rd, 6);
    do_mode(2);
    check("R9 rate decode high", out_lvl, 1);
    check("R9 count kept", count_rd, 6);
    do_load(4);
    check("R2 load after mode write", count_rd, 4);

    // R2 load priority over tick
    do_mode(2);
    do_load(10);
    run_ticks(3);
    check("R6 mid period", count_rd, 7);
    tick_en = 1'b1; reload_val = 16'd3; load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0; tick_en = 1'b0;
    check("R2 load wins over tick", count_rd, 3);
    run_ticks(2);
    check("R6 pulse count", count_rd, 1);
    check("R6 pulse low", out_lvl, 0);
    run_ticks(1);
    check("R6 reload after pulse", count_rd, 3);
    check("R6 pulse ends", out_lvl, 1);

    // R3 zero reload reads back zero
    do_load(0);
    check("R3 zero readback", count_rd, 0);
    run_ticks(1);
    check("R3 zero first tick", count_rd, 65535);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule